// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block keeps the protection state of a serial flash device and rules on every command that could change it. A command decoder presents one decoded command per strobe, with an opcode class, a byte address and, for status writes, the new lock and block-protect values. One clock later the block answers with a response pulse and an accept flag, and it updates its status word on the same edge. The write-protect pin is asynchronous, so it passes through a two-flop synchronizer before it is used.

The status word has three parts. A lock bit, when set together with a low protect pin, freezes the status word; this hardware-locked state can start in either order. A 3-bit protect code covers a power-of-two share at the top of the array. A write-enable latch must be set before any modifying command, and it clears after each one.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, `status_q` is 0, `resp_valid` is 0 and `hw_locked` is 0.
- R2: Opcode 0 (write-enable) is accepted and sets the latch, `status_q[1]`. `resp_valid` is high exactly in the cycle after each strobe and low at all other times.
- R3: Opcodes 1 (status write), 2 (page program), 3 (sector erase) and 4 (bulk erase) are rejected when the latch is clear, and the status word is left unchanged.
- R4: An accepted or rejected command with opcode 1 to 4 clears the latch.
- R5: With the lock bit `status_q[7]` clear, a status write with the latch set is accepted at either pin level. It loads `sr_new[3]` into `status_q[7]` and `sr_new[2:0]` into the protect code `status_q[4:2]`.
- R6: With the lock bit set and the synchronized pin high, a status write with the latch set is accepted, and it can clear the lock bit.
- R7: `hw_locked` equals the lock bit AND the inverted synchronized pin. It is entered whether the bit is set first or the pin goes low first. While it is high, a status write is rejected and `status_q[7:2]` is unchanged.
- R8: The synchronized pin follows the input pin after the second rising clock edge. The only way to leave `hw_locked` is to raise the pin, and no command clears it while the pin stays low.
- R9: For protect code n (1 to 7), byte addresses from 2^19 - 2^(12+n) up to the top of the array are protected, so code 7 covers the whole array. Page program and sector erase are rejected in the protected range and accepted below it.
- R10: Bulk erase is rejected when the protect code is nonzero and accepted when it is zero.
- R11: Opcodes 5 to 7 are rejected and change nothing, including the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin | input | 1 | Write-protect pin, asynchronous, low protects |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 3 | Opcode class |
| cmd_addr | input | 19 | Target byte address |
| sr_new | input | 4 | New status: bit 3 lock, bits 2:0 protect code |
| resp_valid | output | 1 | Response pulse, one cycle after the strobe |
| resp_accept | output | 1 | Command accepted |
| status_q | output | 8 | Status: bit 7 lock, bits 4:2 protect code, bit 1 latch |
| hw_locked | output | 1 | Hardware-locked state |

## Verification
A corrupted latch shows up at the next modifying command as an accept or reject that does not match, on the response one cycle after the strobe. A wrong lock or protect value appears at once in `status_q`. It then shows as the wrong verdict on the next status write, program, erase or bulk erase. An error in the synchronizer or in the lock logic changes `hw_locked`: the bench checks its level one edge after a pin change and again after the second edge, so the reported state must be neither early nor late.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

   typedef enum logic [2:0] {
      OP_WEN  = 3'd0,
      OP_STW  = 3'd1,
      OP_PROG = 3'd2,
      OP_SECT = 3'd3,
      OP_CHIP = 3'd4
   } wp_op_e;

   localparam int unsigned OP_W      = 3;
   localparam int unsigned CODE_W    = 3;
   localparam int unsigned STAT_W    = 8;
   localparam int unsigned LOCK_POS  = 7;
   localparam int unsigned CODE_LO   = 2;
   localparam int unsigned LATCH_POS = 1;

   function automatic logic op_modifies(input logic [OP_W-1:0] op);
      return (op == OP_STW) || (op == OP_PROG) || (op == OP_SECT) || (op == OP_CHIP);
   endfunction

endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   initial begin
      if (STAGES < 2) $error("wp_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RST_VAL;
      else        chain_q[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= RST_VAL;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned CODE_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CODE_W-1:0] code,
   output logic              in_prot
);
   localparam int unsigned NCODES = 1 << CODE_W;
   localparam int unsigned TOPC   = NCODES - 1;

   initial begin
      if (ADDR_W < TOPC) $error("wp_range_decode: ADDR_W too small for CODE_W");
   end

   function automatic logic [ADDR_W-1:0] upper_mask(input int unsigned sh);
      logic [ADDR_W-1:0] m;
      for (int b = 0; b < ADDR_W; b++) m[b] = (b >= sh);
      return m;
   endfunction

   logic [NCODES-1:0] hit;

   assign hit[0] = 1'b0;
   for (genvar c = 1; c < NCODES; c++) begin : g_code
      localparam int unsigned SH = ADDR_W - TOPC + c;
      localparam logic [ADDR_W-1:0] MASK = upper_mask(SH);
      assign hit[c] = ((addr & MASK) == MASK);
   end

   assign in_prot = hit[code];
endmodule

// File: rtl/wp_state_core.sv
module wp_state_core
   import flash_wp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic              new_lock,
   input  logic [CODE_W-1:0] new_code,
   input  logic              pin_hi,
   input  logic              addr_prot,
   output logic              lock_q,
   output logic [CODE_W-1:0] code_q,
   output logic              latch_q,
   output logic              resp_valid,
   output logic              resp_accept
);
   logic grant;
   logic stw_open;

   assign stw_open = !(lock_q && !pin_hi);

   always_comb begin
      unique case (cmd_op)
         OP_WEN:          grant = 1'b1;
         OP_STW:          grant = latch_q && stw_open;
         OP_PROG,
         OP_SECT:         grant = latch_q && !addr_prot;
         OP_CHIP:         grant = latch_q && (code_q == '0);
         default:         grant = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q      <= 1'b0;
         code_q      <= '0;
         latch_q     <= 1'b0;
         resp_valid  <= 1'b0;
         resp_accept <= 1'b0;
      end else begin
         resp_valid  <= cmd_valid;
         resp_accept <= cmd_valid && grant;
         if (cmd_valid) begin
            if (cmd_op == OP_WEN)          latch_q <= 1'b1;
            else if (op_modifies(cmd_op))  latch_q <= 1'b0;
            if ((cmd_op == OP_STW) && grant) begin
               lock_q <= new_lock;
               code_q <= new_code;
            end
         end
      end
   end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
   import flash_wp_pkg::*;
#(
   parameter int unsigned ADDR_W      = 19,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_pin,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [3:0]        sr_new,
   output logic              resp_valid,
   output logic              resp_accept,
   output logic [7:0]        status_q,
   output logic              hw_locked
);
   initial begin
      if (STAT_W != 8) $error("flash_wp_ctrl: status width must be 8");
   end

   logic              pin_hi;
   logic              addr_prot;
   logic              lock_q;
   logic [CODE_W-1:0] code_q;
   logic              latch_q;

   wp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (wp_pin),
      .sync_out (pin_hi)
   );

   wp_range_decode #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) range_i (
      .addr    (cmd_addr),
      .code    (code_q),
      .in_prot (addr_prot)
   );

   wp_state_core core_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_op      (cmd_op),
      .new_lock    (sr_new[3]),
      .new_code    (sr_new[2:0]),
      .pin_hi      (pin_hi),
      .addr_prot   (addr_prot),
      .lock_q      (lock_q),
      .code_q      (code_q),
      .latch_q     (latch_q),
      .resp_valid  (resp_valid),
      .resp_accept (resp_accept)
   );

   always_comb begin
      status_q            = '0;
      status_q[LOCK_POS]  = lock_q;
      status_q[CODE_LO +: CODE_W] = code_q;
      status_q[LATCH_POS] = latch_q;
   end

   assign hw_locked = lock_q && !pin_hi;
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic       resp_valid,
   input logic       resp_accept,
   input logic [7:0] status_q,
   input logic       hw_locked
);
   logic is_mod;
   assign is_mod = (cmd_op >= 3'd1) && (cmd_op <= 3'd4);

   assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $past(cmd_valid));

   assert_wen_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd0) |=> (resp_accept && status_q[1]));

   assert_no_latch_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && is_mod && !status_q[1]) |=> !resp_accept);

   assert_latch_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && is_mod) |=> !status_q[1]);

   assert_locked_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_locked && cmd_valid && cmd_op == 3'd1) |=> (!resp_accept && $stable(status_q[7:2])));

   assert_bulk_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd4 && status_q[4:2] != 3'd0) |=> !resp_accept);

   assert_unknown_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op >= 3'd5) |=> (!resp_accept && $stable(status_q)));
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_op      (cmd_op),
   .resp_valid  (resp_valid),
   .resp_accept (resp_accept),
   .status_q    (status_q),
   .hw_locked   (hw_locked)
);

// File: tb/flash_wp_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb_top;
   localparam int AW = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_pin = 1'b1;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = 3'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic [3:0]    sr_new = 4'd0;
   logic          resp_valid, resp_accept, hw_locked;
   logic [7:0]    status_q;

   int n_chk = 0;
   int n_err = 0;
   logic got_v, got_a;

   always #4 clk = ~clk;

   flash_wp_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .sr_new(sr_new),
      .resp_valid(resp_valid), .resp_accept(resp_accept),
      .status_q(status_q), .hw_locked(hw_locked)
   );

   task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [3:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; sr_new = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      got_v = resp_valid;
      got_a = resp_accept;
   endtask

   task automatic set_code(input logic [2:0] c);
      send(3'd0, '0, 4'd0);
      send(3'd1, '0, {1'b0, c});
   endtask

   function automatic bit model_prot(input int code, input int addr);
      if (code == 0) return 1'b0;
      return addr >= ((1 << AW) - (1 << (AW - 7 + code)));
   endfunction

   task automatic t_reset;
      expect_eq("R1 status", status_q, 8'h00);
      expect_eq("R1 resp_valid", resp_valid, 0);
      expect_eq("R1 hw_locked", hw_locked, 0);
   endtask

   task automatic t_no_latch;
      send(3'd1, '0, 4'hF);
      expect_eq("R3 status write rejected", got_a, 0);
      expect_eq("R3 status unchanged", status_q, 8'h00);
      send(3'd3, '0, 4'h0);
      expect_eq("R3 erase rejected", got_a, 0);
      send(3'd4, '0, 4'h0);
      expect_eq("R3 bulk rejected", got_a, 0);
   endtask

   task automatic t_wen;
      send(3'd0, '0, 4'h0);
      expect_eq("R2 resp pulse", got_v, 1);
      expect_eq("R2 accepted", got_a, 1);
      expect_eq("R2 latch set", status_q[1], 1);
      @(negedge clk);
      expect_eq("R2 pulse ends", resp_valid, 0);
      send(3'd2, 19'h00010, 4'h0);
      expect_eq("R4 program accepted", got_a, 1);
      expect_eq("R4 latch cleared after accept", status_q[1], 0);
   endtask

   task automatic t_unlocked_write;
      wp_pin = 1'b0;
      set_code(3'd3);
      expect_eq("R5 write accepted pin low", got_a, 1);
      expect_eq("R5 status loaded", status_q, 8'h0C);
      send(3'd0, '0, 4'h0);
      send(3'd2, 19'h7FFFF, 4'h0);
      expect_eq("R9 top rejected", got_a, 0);
      expect_eq("R4 latch cleared after reject", status_q[1], 0);
      set_code(3'd0);
      expect_eq("R5 code cleared", status_q, 8'h00);
      @(negedge clk); wp_pin = 1'b1;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic t_pin_first;
      @(negedge clk); wp_pin = 1'b0;
      @(negedge clk); @(negedge clk);
      expect_eq("R7 no lock yet", hw_locked, 0);
      send(3'd0, '0, 4'h0);
      send(3'd1, '0, 4'h9);
      expect_eq("R5 lock write accepted", got_a, 1);
      expect_eq("R7 locked after bit set", hw_locked, 1);
      send(3'd0, '0, 4'h0);
      send(3'd1, '0, 4'h0);
      expect_eq("R7 write rejected when locked", got_a, 0);
      expect_eq("R7 status frozen", status_q, 8'h84);
      @(negedge clk); wp_pin = 1'b1;
      @(negedge clk);
      expect_eq("R8 still locked after one edge", hw_locked, 1);
      @(negedge clk);
      expect_eq("R8 unlocked after second edge", hw_locked, 0);
      send(3'd0, '0, 4'h0);
      send(3'd1, '0, 4'h0);
      expect_eq("R6 write accepted pin high", got_a, 1);
      expect_eq("R6 lock cleared", status_q, 8'h00);
   endtask

   task automatic t_bit_first;
      send(3'd0, '0, 4'h0);
      send(3'd1, '0, 4'h8);
      expect_eq("R6 lock set pin high", status_q[7], 1);
      expect_eq("R7 not locked pin high", hw_locked, 0);
      @(negedge clk); wp_pin = 1'b0;
      @(negedge clk);
      expect_eq("R8 sync delay", hw_locked, 0);
      @(negedge clk);
      expect_eq("R7 locked after pin low", hw_locked, 1);
      for (int k = 0; k < 2; k++) begin
         send(3'd0, '0, 4'h0);
         send(3'd1, '0, 4'h0);
         expect_eq("R8 command cannot unlock", hw_locked, 1);
      end
      expect_eq("R8 status kept", status_q, 8'h80);
      @(negedge clk); wp_pin = 1'b1;
      @(negedge clk); @(negedge clk);
      send(3'd0, '0, 4'h0);
      send(3'd1, '0, 4'h0);
      expect_eq("R6 clear lock", status_q, 8'h00);
   endtask

   task automatic t_ranges;
      int codes[3] = '{1, 4, 7};
      for (int i = 0; i < 3; i++) begin
         int c = codes[i];
         int edge_a = (1 << AW) - (1 << (AW - 7 + c));
         int addrs[3] = '{edge_a, edge_a - 1, 0};
         set_code(c[2:0]);
         for (int j = 0; j < 3; j++) begin
            if (addrs[j] < 0) continue;
            send(3'd0, '0, 4'h0);
            send((j == 1) ? 3'd3 : 3'd2, addrs[j][AW-1:0], 4'h0);
            expect_eq($sformatf("R9 code %0d addr %0h", c, addrs[j]), got_a,
                      !model_prot(c, addrs[j]));
         end
         send(3'd0, '0, 4'h0);
         send(3'd4, '0, 4'h0);
         expect_eq($sformatf("R10 bulk code %0d", c), got_a, 0);
      end
      set_code(3'd0);
      send(3'd0, '0, 4'h0);
      send(3'd4, '0, 4'h0);
      expect_eq("R10 bulk code 0", got_a, 1);
   endtask

   task automatic t_unknown;
      send(3'd0, '0, 4'h0);
      for (int op = 5; op < 8; op++) begin
         send(op[2:0], '0, 4'hF);
         expect_eq("R11 rejected", got_a, 0);
         expect_eq("R11 state kept", status_q, 8'h02);
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_latch();
      t_wen();
      t_unlocked_write();
      t_pin_first();
      t_bit_first();
      t_ranges();
      t_unknown();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule